// File: doc/BRIEF.md
# Chipset Reset Control Register

This block is a one-byte reset control register on a small I/O bus, the kind a PC chipset uses to let software restart the machine. Software writes a byte to one fixed I/O address. A write that moves the trigger bit from clear to set starts a reset. The same written byte also says which kind of reset: a processor-only restart, or a full platform restart that also resets the peripherals and the PCI bus.

The block drives two registered pulses, each one clock wide. One goes to the processor. The other is a single shared line that fans out to the disk controllers, the keyboard controller, the legacy port logic and PCI. The register's own contents are cleared only by the external synchronous reset input, never by the pulses it produces. Reads return the stored byte with the trigger bit hidden. The reset-type select bit is never kept in storage.

Top module: `io_reset_ctrl`

## Requirements
- R1: While `rst` is high, the stored byte is cleared to 0x00. After reset, a read returns 0x00 and both pulse outputs are low.
- R2: Only an access whose full 16-bit address equals 0x0CF9 is decoded. Writes to any other address leave the stored byte unchanged and produce no pulse. Reads of any other address return 0x00 on `io_rdata`.
- R3: A reset is triggered only when the written byte has bit 2 set while the stored byte has bit 2 clear. A write with bit 2 set while stored bit 2 is already set triggers nothing.
- R4: On a trigger with bit 1 of the written byte set (full reset), `plat_rst_pulse` and `cpu_rst_pulse` are both asserted, in the same cycle.
- R5: On a trigger with bit 1 of the written byte clear (processor-only reset), only `cpu_rst_pulse` is asserted and `plat_rst_pulse` stays low.
- R6: Each accepted write stores the written byte with bit 1 forced to 0. All other bits are kept as written.
- R7: A read of 0x0CF9 returns the stored byte with bit 2 forced to 0.
- R8: Each pulse is exactly one clock wide. It is high for the single cycle after the clock edge that captured the triggering write.
- R9: A read and a write to 0x0CF9 in the same cycle return the stored value from before that write.
- R10: `plat_rst_pulse` is never high in a cycle in which `cpu_rst_pulse` is low, so the peripheral reset never comes after the processor reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; zero when not reading the register |
| cpu_rst_pulse | output | 1 | One-cycle processor reset pulse |
| plat_rst_pulse | output | 1 | One-cycle peripheral and PCI reset pulse |

## Verification
Two functions can fall in the same cycle: a read of the register and a write to it. The bench provokes this by raising both strobes together at 0x0CF9. It judges the combinational read data in that cycle against the stored value from before the write. It also checks that a triggering write made during such a read still produces its pulses in the following cycle. A second case of same-cycle behaviour is the full reset, where the bench requires the processor and peripheral pulses to be high together in the one cycle after the write.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int DATA_W    = 8;
    localparam int TRIG_BIT  = 2;   // clear-to-set starts a reset
    localparam int SEL_BIT   = 1;   // 1 = full platform, 0 = processor only

    localparam logic [DATA_W-1:0] SEL_MASK  = DATA_W'(1) << SEL_BIT;
    localparam logic [DATA_W-1:0] TRIG_MASK = DATA_W'(1) << TRIG_BIT;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_CPU  = 2'd1,
        KIND_FULL = 2'd2
    } rst_kind_e;

    typedef struct packed {
        logic cpu;
        logic plat;
    } pulse_t;

    // Value kept in storage: select bit never persists.
    function automatic byte_t store_view(input byte_t wr_byte);
        return wr_byte & ~SEL_MASK;
    endfunction

    // Value presented on reads: trigger bit always appears clear.
    function automatic byte_t read_view(input byte_t held);
        return held & ~TRIG_MASK;
    endfunction

    // Decide what kind of reset a write requests given current storage.
    function automatic rst_kind_e classify(input byte_t wr_byte, input byte_t held);
        if (wr_byte[TRIG_BIT] && !held[TRIG_BIT]) begin
            return wr_byte[SEL_BIT] ? KIND_FULL : KIND_CPU;
        end
        return KIND_NONE;
    endfunction

    function automatic pulse_t kind_to_pulse(input rst_kind_e k);
        pulse_t p;
        p.cpu  = (k != KIND_NONE);
        p.plat = (k == KIND_FULL);
        return p;
    endfunction

endpackage

// File: rtl/rstc_decode.sv
module rstc_decode #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] MATCH  = 16'h0CF9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic addr_eq;

    always_comb begin
        addr_eq = (addr == MATCH);
        wr_hit  = wr && addr_eq;
        rd_hit  = rd && addr_eq;
    end

    AST_HIT_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (wr_hit || rd_hit) |-> (addr == MATCH)); // R2

endmodule

// File: rtl/rstc_store.sv
module rstc_store
    import rstc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hit,
    input  logic  rd_hit,
    input  byte_t wdata,
    output byte_t held,
    output byte_t rdata
);

    byte_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (wr_hit) begin
            held_q <= store_view(wdata);
        end
    end

    // Read path is combinational from storage, so a same-cycle write
    // is seen only from the next cycle on.
    always_comb begin
        held  = held_q;
        rdata = rd_hit ? read_view(held_q) : '0;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (held_q == '0)); // R1
    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(held_q)); // R2
    AST_SEL_NOT_KEPT: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (held_q[SEL_BIT] == 1'b0)); // R6
    AST_TRIG_READS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (rdata[TRIG_BIT] == 1'b0)); // R7
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> (rdata == '0)); // R2

endmodule

// File: rtl/rstc_pulse.sv
module rstc_pulse
    import rstc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hit,
    input  byte_t wdata,
    input  byte_t held,
    output logic  cpu_pulse,
    output logic  plat_pulse
);

    rst_kind_e kind;
    pulse_t    next_p;
    pulse_t    cur_p;

    always_comb begin
        kind   = wr_hit ? classify(wdata, held) : KIND_NONE;
        next_p = kind_to_pulse(kind);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_p <= '0;
        end else begin
            cur_p <= next_p;
        end
    end

    assign cpu_pulse  = cur_p.cpu;
    assign plat_pulse = cur_p.plat;

    AST_EDGE_FIRES: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wdata[TRIG_BIT] && !held[TRIG_BIT]) |=> cpu_pulse); // R3
    AST_LEVEL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && held[TRIG_BIT]) |=> !cpu_pulse); // R3
    AST_NO_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> !(cpu_pulse || plat_pulse)); // R2
    AST_SOFT_ONLY_CPU: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !wdata[SEL_BIT]) |=> !plat_pulse); // R5
    AST_PLAT_WITH_CPU: assert property (@(posedge clk) disable iff (rst)
        plat_pulse |-> cpu_pulse); // R10
    AST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        cpu_pulse |=> !cpu_pulse); // R8

endmodule

// File: rtl/io_reset_ctrl.sv
module io_reset_ctrl
    import rstc_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0CF9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cpu_rst_pulse,
    output logic              plat_rst_pulse
);

    logic  wr_hit;
    logic  rd_hit;
    byte_t held;

    rstc_decode #(
        .ADDR_W (ADDR_W),
        .MATCH  (REG_ADDR)
    ) u_decode (
        .clk    (clk),
        .rst    (rst),
        .addr   (io_addr),
        .wr     (io_wr),
        .rd     (io_rd),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    rstc_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit),
        .wdata  (io_wdata),
        .held   (held),
        .rdata  (io_rdata)
    );

    rstc_pulse u_pulse (
        .clk        (clk),
        .rst        (rst),
        .wr_hit     (wr_hit),
        .wdata      (io_wdata),
        .held       (held),
        .cpu_pulse  (cpu_rst_pulse),
        .plat_pulse (plat_rst_pulse)
    );

endmodule

// File: tb/io_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module io_reset_ctrl_tb_top;

    localparam logic [15:0] REG = 16'h0CF9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cpu_rst_pulse;
    logic        plat_rst_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    io_reset_ctrl dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cpu_rst_pulse(cpu_rst_pulse), .plat_rst_pulse(plat_rst_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Write one byte; report pulses in the first and second cycle after.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                            output logic [1:0] p1, output logic [1:0] p2);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        p1 = {plat_rst_pulse, cpu_rst_pulse};
        @(negedge clk);
        p2 = {plat_rst_pulse, cpu_rst_pulse};
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(cpu_rst_pulse == 0 && plat_rst_pulse == 0, "R1 pulses low in reset",
              {plat_rst_pulse, cpu_rst_pulse}, 0);
        do_read(REG, d);
        check(d == 8'h00, "R1 reset value", d, 0);
    endtask

    task automatic t_soft();
        logic [1:0] p1, p2; logic [7:0] d;
        do_write(REG, 8'h04, p1, p2);
        check(p1 == 2'b01, "R5 cpu-only pulse", p1, 1);
        check(p2 == 2'b00, "R8 pulse one cycle", p2, 0);
        do_read(REG, d);
        check(d == 8'h00, "R7 trigger bit reads clear", d, 0);
    endtask

    task automatic t_rearm();
        logic [1:0] p1, p2;
        do_write(REG, 8'h06, p1, p2);
        check(p1 == 2'b00 && p2 == 2'b00, "R3 no pulse when already set", p1, 0);
        do_write(REG, 8'h00, p1, p2);
        check(p1 == 2'b00, "R3 clearing write silent", p1, 0);
        do_write(REG, 8'h06, p1, p2);
        check(p1 == 2'b11, "R4 full reset both pulses", p1, 3);
        check(p1[1] <= p1[0], "R10 plat not without cpu", p1, 3);
        check(p2 == 2'b00, "R8 full pulses one cycle", p2, 0);
    endtask

    task automatic t_store();
        logic [1:0] p1, p2; logic [7:0] d;
        do_write(REG, 8'h00, p1, p2);
        do_write(REG, 8'hFB, p1, p2);
        check(p1 == 2'b00, "R3 bit2 clear no pulse", p1, 0);
        do_read(REG, d);
        check(d == 8'hF9, "R6 bit1 not stored", d, 8'hF9);
        do_write(REG, 8'hFF, p1, p2);
        check(p1 == 2'b11, "R4 full reset from 0xFF", p1, 3);
        do_read(REG, d);
        check(d == 8'hF9, "R7 read masks bit2", d, 8'hF9);
    endtask

    task automatic t_decode();
        logic [1:0] p1, p2; logic [7:0] d;
        do_write(16'h0CF8, 8'h00, p1, p2);
        do_read(REG, d);
        check(d == 8'hF9, "R2 other address write ignored", d, 8'hF9);
        do_read(16'h0CF8, d);
        check(d == 8'h00, "R2 other address read zero", d, 0);
        do_write(REG, 8'h00, p1, p2);
        do_write(16'h0CF8, 8'h04, p1, p2);
        check(p1 == 2'b00, "R2 no pulse at 0x0CF8", p1, 0);
        do_write(16'h1CF9, 8'h06, p1, p2);
        check(p1 == 2'b00, "R2 no pulse at 0x1CF9", p1, 0);
        do_write(16'h0CFA, 8'h38, p1, p2);
        do_read(REG, d);
        check(d == 8'h00, "R2 storage untouched", d, 0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d; logic [1:0] p1;
        @(negedge clk);
        io_addr = REG; io_wdata = 8'h38; io_wr = 1'b1; io_rd = 1'b1;
        #1 d = io_rdata;
        check(d == 8'h00, "R9 read sees old value", d, 0);
        @(negedge clk);
        io_wr = 1'b0;
        #1 d = io_rdata;
        check(d == 8'h38, "R9 new value next cycle", d, 8'h38);
        io_wdata = 8'h3E; io_wr = 1'b1;
        #1 d = io_rdata;
        check(d == 8'h38, "R9 old value during trigger", d, 8'h38);
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        p1 = {plat_rst_pulse, cpu_rst_pulse};
        check(p1 == 2'b11, "R4 trigger during read", p1, 3);
        do_read(REG, d);
        check(d == 8'h38, "R6 stored 0x3C reads 0x38", d, 8'h38);
    endtask

    task automatic t_rerst();
        logic [7:0] d;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_read(REG, d);
        check(d == 8'h00, "R1 reset clears storage", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_soft();
        t_rearm();
        t_store();
        t_decode();
        t_same_cycle();
        t_rerst();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule